// File: doc/BRIEF.md
# CCD Shift Gate Pulse Generator

This block generates the shift gate pulses that move charge from the photosites of an interline CCD into its shielded vertical registers. It drives a bank of vertical output channels. Each channel either passes through a vertical transfer waveform from an external sequencer, or acts as a shift gate. A shift gate channel rests at a start polarity and, on the chosen lines of a field, inverts between two programmed pixel positions.

Timing comes from two sync inputs. A field sync (`vd`) restarts a line counter, and a line sync (`hd`) advances that counter and restarts a pixel counter. The selection, toggle-pair and mask words and the two active-line numbers are captured on the field sync, so software may rewrite them at any time during a field. A one-clock strobe marks the start of the first active line, which is the reference point for a separate substrate clock engine.

Top module: `sg_pulse_gen`

## Requirements
- R1: A rising edge on `vd` sets both the line and the pixel counter to 0. Otherwise a rising edge on `hd` sets the pixel counter to 0 and advances the line counter. On all other cycles the pixel counter advances by one. Both counters saturate at their all-ones value. Reset loads both counters with all-ones.
- R2: Channel c with select bit `cfg_sel[c]`=0 drives `v_out[c]` equal to `xv_in[c]` delayed by one clock.
- R3: A selected, unmasked channel on an active line outputs `cfg_pol[c]` inverted while the pixel count p satisfies first ≤ p < second. The output changes one clock after the counter holds that value.
- R4: The four toggle positions of channel c sit in `cfg_tog` at bits [(4c+k)*PIX_W +: PIX_W] for k = 0..3. A pair bit of 0 uses k=0 (first) and k=1 (second). A pair bit of 1 uses k=2 and k=3. The unused pair has no effect.
- R5: A selected channel whose mask bit is 1 holds `cfg_pol[c]` for the whole field.
- R6: On a line that is not active, a selected channel holds `cfg_pol[c]`.
- R7: A line is active when it equals the first active line, or when it equals the second active line and the second is not all-ones. If the second equals the first or is all-ones, no extra pulse occurs.
- R8: `sub_strobe` is high for exactly one clock. That clock is the one after the counters hold line = first active line and pixel = 0.
- R9: Select, pair, mask and both active-line values take effect only from the next `vd` rising edge. Changes made during a field have no effect on that field.
- R10: If the second toggle is less than or equal to the first, the channel inverts at the first toggle and stays inverted until the line ends.
- R11: While reset is held, `v_out` and `sub_strobe` are 0. After reset, all channels pass `xv_in` through until the first field sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vd | input | 1 | Field sync; its rising edge starts a field |
| hd | input | 1 | Line sync; its rising edge starts a line |
| xv_in | input | NUM_CH | Vertical transfer waveform from the external sequencer |
| cfg_sel | input | NUM_CH | 1 = channel is a shift gate |
| cfg_pat | input | NUM_CH | Toggle pair per channel: 0 = positions 1/2, 1 = positions 3/4 |
| cfg_mask | input | NUM_CH | 1 = suppress this channel's pulse in the field |
| cfg_pol | input | NUM_CH | Start polarity per channel |
| cfg_tog | input | NUM_CH*4*PIX_W | Four toggle pixel positions per channel |
| cfg_line_a | input | LINE_W | First active line |
| cfg_line_b | input | LINE_W | Second active line |
| v_out | output | NUM_CH | Vertical channel outputs |
| sub_strobe | output | 1 | One-clock mark at the start of the first active line |

## Verification
The bench builds the block with 24 channels, a 4-bit line counter and a 6-bit pixel counter, using 40-clock lines. The narrow line counter lets a field of 18 lines reach the all-ones line, so the saturation of the line counter and the disabled second line are both tested. The 40-clock lines keep every random toggle position inside a line. Random fields and directed fields are mixed: a second line equal to the first, a second line at all-ones, a reversed toggle pair, full masking, the upper toggle pair, and a configuration rewrite in the middle of a field.

// File: rtl/sg_pkg.sv
// Shared definitions for the shift gate pulse generator.
// Assumes: nothing beyond standard SystemVerilog.
package sg_pkg;
    // Number of toggle positions each channel pattern holds.
    localparam int TOGS_PER_CH = 4;

    // Which pair of toggle positions a shift gate channel uses.
    typedef enum logic {
        PAIR_LOW  = 1'b0,   // positions 1 and 2
        PAIR_HIGH = 1'b1    // positions 3 and 4
    } tog_pair_e;
endpackage

// File: rtl/sg_timebase.sv
// Line and pixel counters driven by the field and line syncs.
// Assumes vd/hd are synchronous to clk; only their rising edges matter.
// Field sync has priority over line sync; both counters saturate.
module sg_timebase #(
    parameter int LINE_W = 13,
    parameter int PIX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vd,
    input  logic              hd,
    output logic              vd_rise,
    output logic [LINE_W-1:0] line_cnt,
    output logic [PIX_W-1:0]  pix_cnt
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};
    localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};

    logic vd_q;
    logic hd_q;
    logic hd_rise;

    assign vd_rise = vd & ~vd_q;
    assign hd_rise = hd & ~hd_q;

    // Remember previous sync levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_q <= 1'b0;
            hd_q <= 1'b0;
        end else begin
            vd_q <= vd;
            hd_q <= hd;
        end
    end

    // Advance the line and pixel position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= LINE_MAX;
            pix_cnt  <= PIX_MAX;
        end else if (vd_rise) begin
            line_cnt <= '0;
            pix_cnt  <= '0;
        end else if (hd_rise) begin
            pix_cnt <= '0;
            if (line_cnt != LINE_MAX) begin
                line_cnt <= line_cnt + 1'b1;
            end
        end else if (pix_cnt != PIX_MAX) begin
            pix_cnt <= pix_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sg_field_cfg.sv
// Field-synchronous shadow of the per-field configuration.
// Assumes the live configuration may change at any time; the shadow
// copies it only on the field sync rising edge.
module sg_field_cfg #(
    parameter int NUM_CH = 24,
    parameter int LINE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vd_rise,
    input  logic [NUM_CH-1:0] cfg_sel,
    input  logic [NUM_CH-1:0] cfg_pat,
    input  logic [NUM_CH-1:0] cfg_mask,
    input  logic [LINE_W-1:0] cfg_line_a,
    input  logic [LINE_W-1:0] cfg_line_b,
    output logic [NUM_CH-1:0] sel_sh,
    output logic [NUM_CH-1:0] pat_sh,
    output logic [NUM_CH-1:0] mask_sh,
    output logic [LINE_W-1:0] line_a_sh,
    output logic [LINE_W-1:0] line_b_sh
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    // Capture the configuration at the start of each field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_sh    <= '0;
            pat_sh    <= '0;
            mask_sh   <= '1;
            line_a_sh <= LINE_MAX;
            line_b_sh <= LINE_MAX;
        end else if (vd_rise) begin
            sel_sh    <= cfg_sel;
            pat_sh    <= cfg_pat;
            mask_sh   <= cfg_mask;
            line_a_sh <= cfg_line_a;
            line_b_sh <= cfg_line_b;
        end
    end
endmodule

// File: rtl/sg_channel.sv
// One vertical output channel: transfer pass-through or shift gate.
// Assumes line_act and pix_cnt come from registers; output is registered,
// so it reflects the counter values of the previous clock.
module sg_channel
    import sg_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel,
    input  logic                        pat,
    input  logic                        mask,
    input  logic                        pol,
    input  logic [TOGS_PER_CH*PIX_W-1:0] tog,
    input  logic                        line_act,
    input  logic [PIX_W-1:0]            pix_cnt,
    input  logic                        xv_bit,
    output logic                        v_bit
);
    tog_pair_e        pair;
    logic [PIX_W-1:0] t_first;
    logic [PIX_W-1:0] t_second;
    logic             in_window;
    logic             sg_level;

    assign pair = tog_pair_e'(pat);

    // Pick the toggle pair for this channel.
    always_comb begin
        if (pair == PAIR_HIGH) begin
            t_first  = tog[2*PIX_W +: PIX_W];
            t_second = tog[3*PIX_W +: PIX_W];
        end else begin
            t_first  = tog[0*PIX_W +: PIX_W];
            t_second = tog[1*PIX_W +: PIX_W];
        end
    end

    // Inverted between first and second toggle; open-ended if reversed.
    always_comb begin
        in_window = (pix_cnt >= t_first) &&
                    ((pix_cnt < t_second) || (t_second <= t_first));
        sg_level  = pol ^ (line_act & ~mask & in_window);
    end

    // Register the channel output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_bit <= 1'b0;
        end else begin
            v_bit <= sel ? sg_level : xv_bit;
        end
    end
endmodule

// File: rtl/sg_pulse_gen.sv
// Shift gate pulse generator for a bank of vertical CCD channels.
// Assumes: syncs are synchronous to clk; toggle positions and polarity
// are static pattern settings used live; field settings are shadowed.
module sg_pulse_gen
    import sg_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int LINE_W = 13,
    parameter int PIX_W  = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              vd,
    input  logic                              hd,
    input  logic [NUM_CH-1:0]                 xv_in,
    input  logic [NUM_CH-1:0]                 cfg_sel,
    input  logic [NUM_CH-1:0]                 cfg_pat,
    input  logic [NUM_CH-1:0]                 cfg_mask,
    input  logic [NUM_CH-1:0]                 cfg_pol,
    input  logic [NUM_CH*TOGS_PER_CH*PIX_W-1:0] cfg_tog,
    input  logic [LINE_W-1:0]                 cfg_line_a,
    input  logic [LINE_W-1:0]                 cfg_line_b,
    output logic [NUM_CH-1:0]                 v_out,
    output logic                              sub_strobe
);
    localparam int                TOG_W    = TOGS_PER_CH * PIX_W;
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic              vd_rise;
    logic [LINE_W-1:0] line_cnt;
    logic [PIX_W-1:0]  pix_cnt;
    logic [NUM_CH-1:0] sel_sh;
    logic [NUM_CH-1:0] pat_sh;
    logic [NUM_CH-1:0] mask_sh;
    logic [LINE_W-1:0] line_a_sh;
    logic [LINE_W-1:0] line_b_sh;
    logic              line_act;

    sg_timebase #(
        .LINE_W (LINE_W),
        .PIX_W  (PIX_W)
    ) timebase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .vd       (vd),
        .hd       (hd),
        .vd_rise  (vd_rise),
        .line_cnt (line_cnt),
        .pix_cnt  (pix_cnt)
    );

    sg_field_cfg #(
        .NUM_CH (NUM_CH),
        .LINE_W (LINE_W)
    ) field_cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .vd_rise    (vd_rise),
        .cfg_sel    (cfg_sel),
        .cfg_pat    (cfg_pat),
        .cfg_mask   (cfg_mask),
        .cfg_line_a (cfg_line_a),
        .cfg_line_b (cfg_line_b),
        .sel_sh     (sel_sh),
        .pat_sh     (pat_sh),
        .mask_sh    (mask_sh),
        .line_a_sh  (line_a_sh),
        .line_b_sh  (line_b_sh)
    );

    // Decode whether the current line carries shift gate pulses.
    always_comb begin
        line_act = (line_cnt == line_a_sh) ||
                   ((line_cnt == line_b_sh) && (line_b_sh != LINE_MAX));
    end

    // Mark the first clock of the first active line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_strobe <= 1'b0;
        end else begin
            sub_strobe <= (line_cnt == line_a_sh) && (pix_cnt == '0);
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sg_channel #(
            .PIX_W (PIX_W)
        ) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel_sh[g]),
            .pat      (pat_sh[g]),
            .mask     (mask_sh[g]),
            .pol      (cfg_pol[g]),
            .tog      (cfg_tog[g*TOG_W +: TOG_W]),
            .line_act (line_act),
            .pix_cnt  (pix_cnt),
            .xv_bit   (xv_in[g]),
            .v_bit    (v_out[g])
        );
    end
endmodule

// File: rtl/sg_pulse_gen_chk.sv
// Property checker for sg_pulse_gen, attached with bind.
// Assumes it sees the shadowed field settings and the line decode.
module sg_pulse_gen_chk #(
    parameter int NUM_CH = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vd_rise,
    input logic              line_act,
    input logic [NUM_CH-1:0] sel_sh,
    input logic [NUM_CH-1:0] mask_sh,
    input logic [NUM_CH-1:0] cfg_pol,
    input logic [NUM_CH-1:0] xv_in,
    input logic [NUM_CH-1:0] v_out,
    input logic              sub_strobe
);
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((v_out ^ $past(xv_in)) & ~$past(sel_sh)) == '0));

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((v_out ^ $past(cfg_pol)) & $past(sel_sh & mask_sh)) == '0));

    p_idle_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(line_act)) |->
            (((v_out ^ $past(cfg_pol)) & $past(sel_sh)) == '0));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sub_strobe |=> !sub_strobe);

    p_strobe_on_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sub_strobe) |-> $past(line_act));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(sel_sh)) |-> $past(vd_rise));
endmodule

bind sg_pulse_gen sg_pulse_gen_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vd_rise    (vd_rise),
    .line_act   (line_act),
    .sel_sh     (sel_sh),
    .mask_sh    (mask_sh),
    .cfg_pol    (cfg_pol),
    .xv_in      (xv_in),
    .v_out      (v_out),
    .sub_strobe (sub_strobe)
);

// File: tb/sg_pulse_gen_tb_top.sv
// Self-checking bench: random and directed fields against a bench model.
module sg_pulse_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 24;
    localparam int LW         = 4;
    localparam int PW         = 6;
    localparam int LINE_LEN   = 40;
    localparam int LMAX       = (1 << LW) - 1;
    localparam int PMAX       = (1 << PW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vd = 1'b0;
    logic              hd = 1'b0;
    logic [NCH-1:0]    xv_in = '0;
    logic [NCH-1:0]    cfg_sel = '0;
    logic [NCH-1:0]    cfg_pat = '0;
    logic [NCH-1:0]    cfg_mask = '0;
    logic [NCH-1:0]    cfg_pol = '0;
    logic [NCH*4*PW-1:0] cfg_tog = '0;
    logic [LW-1:0]     cfg_line_a = '0;
    logic [LW-1:0]     cfg_line_b = '0;
    logic [NCH-1:0]    v_out;
    logic              sub_strobe;

    sg_pulse_gen #(.NUM_CH(NCH), .LINE_W(LW), .PIX_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd), .xv_in(xv_in),
        .cfg_sel(cfg_sel), .cfg_pat(cfg_pat), .cfg_mask(cfg_mask),
        .cfg_pol(cfg_pol), .cfg_tog(cfg_tog), .cfg_line_a(cfg_line_a),
        .cfg_line_b(cfg_line_b), .v_out(v_out), .sub_strobe(sub_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "init";

    // Bench model state (values held before the next edge).
    int m_line = LMAX;
    int m_pix = PMAX;
    bit m_vdq = 1'b0;
    bit m_hdq = 1'b0;
    logic [NCH-1:0] s_sel = '0;
    logic [NCH-1:0] s_pat = '0;
    logic [NCH-1:0] s_mask = '1;
    int s_la = LMAX;
    int s_lb = LMAX;

    function automatic int tog_of(int c, int k);
        return int'(cfg_tog[(c*4+k)*PW +: PW]);
    endfunction

    function automatic bit line_active(int line);
        return (line == s_la) || ((line == s_lb) && (s_lb != LMAX));
    endfunction

    function automatic logic exp_level(int c, int line, int pix);
        int ta = s_pat[c] ? tog_of(c, 2) : tog_of(c, 0);
        int tb = s_pat[c] ? tog_of(c, 3) : tog_of(c, 1);
        bit inv = line_active(line) && !s_mask[c] && (pix >= ta) &&
                  ((pix < tb) || (tb <= ta));
        return cfg_pol[c] ^ inv;
    endfunction

    function automatic string class_of(int c, int line);
        int ta = s_pat[c] ? tog_of(c, 2) : tog_of(c, 0);
        int tb = s_pat[c] ? tog_of(c, 3) : tog_of(c, 1);
        if (!s_sel[c]) return "R2";
        if (s_mask[c]) return "R5";
        if (!line_active(line)) return "R6";
        if (tb <= ta) return "R10";
        if (line == s_lb && line != s_la) return "R7";
        if (s_pat[c]) return "R4";
        return "R3";
    endfunction

    // One clock: drive at negedge, predict, step the model, compare.
    task automatic tick(bit v, bit h);
        logic [NCH-1:0] e_out;
        logic           e_stb;
        string          cls [NCH];
        vd = v;
        hd = h;
        xv_in = NCH'($urandom);
        for (int c = 0; c < NCH; c++) begin
            e_out[c] = s_sel[c] ? exp_level(c, m_line, m_pix) : xv_in[c];
            cls[c]   = class_of(c, m_line);
        end
        e_stb = (m_line == s_la) && (m_pix == 0);
        if (v && !m_vdq) begin
            m_line = 0; m_pix = 0;
            s_sel = cfg_sel; s_pat = cfg_pat; s_mask = cfg_mask;
            s_la = int'(cfg_line_a); s_lb = int'(cfg_line_b);
        end else if (h && !m_hdq) begin
            m_pix = 0;
            if (m_line < LMAX) m_line++;
        end else if (m_pix < PMAX) begin
            m_pix++;
        end
        m_vdq = v;
        m_hdq = h;
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (v_out !== e_out) begin
            n_bad++;
            for (int c = 0; c < NCH; c++)
                if (v_out[c] !== e_out[c])
                    $display("FAIL %s [%s] ch%0d v_out got %b exp %b", cls[c], phase,
                             c, v_out[c], e_out[c]);
        end
        n_cmp++;
        if (sub_strobe !== e_stb) begin
            n_bad++;
            $display("FAIL R8 [%s] sub_strobe got %b exp %b", phase, sub_strobe, e_stb);
        end
    endtask

    task automatic rand_cfg(int nlines);
        cfg_sel  = NCH'($urandom);
        cfg_pat  = NCH'($urandom);
        cfg_mask = NCH'($urandom) & NCH'($urandom);
        cfg_pol  = NCH'($urandom);
        for (int i = 0; i < NCH*4; i++)
            cfg_tog[i*PW +: PW] = PW'($urandom_range(0, LINE_LEN - 1));
        cfg_line_a = LW'($urandom_range(0, nlines - 1));
        cfg_line_b = LW'($urandom_range(0, nlines - 1));
    endtask

    // A field of nlines lines; optionally rewrite config at line chg.
    task automatic run_field(int nlines, int chg);
        for (int l = 0; l < nlines; l++) begin
            if (l == chg) rand_cfg(nlines);
            for (int t = 0; t < LINE_LEN; t++)
                tick((l == 0) && (t < 3), t < 2);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        @(negedge clk);
        repeat (4) @(negedge clk);
        // R11: reset state of outputs
        n_cmp++;
        if (v_out !== '0 || sub_strobe !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset v_out got %h exp 0 strobe got %b exp 0", v_out, sub_strobe);
        end
        rst_n = 1'b1;
        phase = "R11 pre-field passthrough";
        rand_cfg(8);
        for (int i = 0; i < 20; i++) tick(1'b0, i % 10 == 0);

        phase = "random R3 R4 R5";
        for (int f = 0; f < 6; f++) begin
            rand_cfg(8);
            run_field(8, -1);
        end

        phase = "R7 second equals first";
        rand_cfg(6);
        cfg_line_b = cfg_line_a;
        run_field(6, -1);

        phase = "R1 R7 second at all-ones, counter saturates";
        rand_cfg(6);
        cfg_line_a = LW'(3);
        cfg_line_b = LW'(LMAX);
        run_field(LMAX + 3, -1);

        phase = "R10 reversed toggles";
        rand_cfg(5);
        cfg_sel = '1; cfg_mask = '0;
        for (int c = 0; c < NCH; c++) begin
            cfg_tog[(c*4+1)*PW +: PW] = PW'($urandom_range(0, 10));
            cfg_tog[(c*4+0)*PW +: PW] = PW'($urandom_range(10, 30));
            cfg_tog[(c*4+3)*PW +: PW] = cfg_tog[(c*4+1)*PW +: PW];
            cfg_tog[(c*4+2)*PW +: PW] = cfg_tog[(c*4+0)*PW +: PW];
        end
        run_field(5, -1);

        phase = "R4 upper pair";
        rand_cfg(5);
        cfg_sel = '1; cfg_mask = '0; cfg_pat = '1;
        run_field(5, -1);

        phase = "R5 all masked";
        rand_cfg(5);
        cfg_sel = '1; cfg_mask = '1;
        run_field(5, -1);

        phase = "R9 mid-field rewrite";
        rand_cfg(8);
        run_field(8, 2);
        run_field(8, 5);

        phase = "random tail";
        for (int f = 0; f < 3; f++) begin
            rand_cfg(8);
            run_field(8, -1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule